// File: doc/BRIEF.md
# Drum Pattern Step Sequencer

This block stores and plays back rhythm patterns for a small drum machine. Storage is a register array of 256 words, 4 bits each. One bit lane per word is the accent flag and the other three lanes trigger bass, snare and rim voices. A word is addressed by the selected rhythm, a variation bit and a 4-bit step number. Sound generation and the tempo oscillator sit outside the block. The tempo arrives as a square wave sampled on the system clock. The start and stop buttons arrive already synchronized and debounced.

In play mode, a start press sets a run flag and a stop press clears it. While the flag is clear, the step counter is held at zero. While it is set, each falling edge of the tempo wave moves to the next step. Triggers are shown only while the sampled tempo is high, so each trigger is a half-period pulse. The hi-hat does not read storage: it follows the step count, firing on every step or on every other step. The variation bit is either fixed by an input or taken from the fifth counter bit, which alternates the two variations every 16 steps.

In write mode, the buttons act as a data key: start enters a 1 and stop enters a 0. Each press writes that value into the lane chosen by the track select and keeps the other three lanes of the word. A write occurs a fixed number of clocks after the press and again after the release. The step advances once the release write has completed.

Top module: `drumStepSeq`

## Requirements
- R1: The storage address is {rhythmSel[2:0], variation bit, step[3:0]}, most significant field first, where step is the low 4 bits of the 5-bit step counter.
- R2: A rising edge of startBtn sets the run flag and a rising edge of stopBtn clears it. If both rise in the same clock, the flag ends up clear.
- R3: In play mode with the run flag clear, the step counter is held at 0 and all triggers stay low whatever the tempo input does.
- R4: In play mode with the run flag set, the counter advances by one on every clock where the sampled tempo was high and the tempo input is now low. The counter is 5 bits wide and wraps from 31 to 0.
- R5: With varAuto high, the variation bit is counter bit 4. With varAuto low, it equals varSel (0 selects A, 1 selects B).
- R6: In write mode, a button press edge causes a write WR_DELAY clocks later. The write puts the run flag value (1 after start, 0 after stop) into lane trackSel of the addressed word and leaves the other three lanes unchanged.
- R7: In write mode, a button release edge causes a second write WR_DELAY clocks later. The counter advances one clock after that write, so each full press moves exactly one step.
- R8: Lane 0 is the accent, lane 1 the bass, lane 2 the snare and lane 3 the rim. A trigger output equals its lane only in play mode while running with the registered tempo high; otherwise it is 0.
- R9: accentExt follows gated lane 0 at all times. trigAccent follows it only while extAccent is low, and is 0 while extAccent is high.
- R10: With hatHalf low, trigHat fires during every gated high phase. With hatHalf high, it fires only when counter bit 0 is 0.
- R11: Reset clears every storage word to 0. Stored words are kept across mode changes and stop/start.
- R12: Any change of modeWrite clears the step counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| modeWrite | input | 1 | 1 selects write mode, 0 selects play mode |
| startBtn | input | 1 | Start button level, synchronized and debounced |
| stopBtn | input | 1 | Stop button level, synchronized and debounced |
| tempoClk | input | 1 | Tempo square wave |
| rhythmSel | input | 3 | Rhythm number |
| varAuto | input | 1 | 1 makes the variation alternate from the counter |
| varSel | input | 1 | Fixed variation: 0 is A, 1 is B |
| trackSel | input | 2 | Lane written in write mode |
| hatHalf | input | 1 | 1 fires the hi-hat on every other step |
| extAccent | input | 1 | External accent connected; mutes the internal accent |
| trigAccent | output | 1 | Internal accent strobe |
| trigBass | output | 1 | Bass trigger |
| trigSnare | output | 1 | Snare trigger |
| trigRim | output | 1 | Rim trigger |
| trigHat | output | 1 | Hi-hat trigger |
| accentExt | output | 1 | Accent strobe for the external jack |

## Verification
Two functions can act on the run flag in the same clock: a start edge and a stop edge. The bench presses both buttons at the same clock edge while a pattern is playing. It then judges the result at the ports: the next tempo high phase must show no triggers, and after a clean start the pattern must resume at step 0. It also checks that a write and a step advance never share a cycle, by confirming that every written step plays back with the exact bits entered across all four lanes.

// File: rtl/seqPkg.sv
package seqPkg;
  localparam int LANE_COUNT = 4;
  localparam int LANE_SEL_W = $clog2(LANE_COUNT);

  // strobes from the control path into the datapath
  typedef struct packed {
    logic wrEn;     // write the addressed word this cycle
    logic wrBit;    // value entered into the selected lane
    logic stepInc;  // advance the step counter
    logic stepClr;  // force the step counter to zero
    logic gate;     // triggers visible
  } seqStrobe_t;
endpackage

// File: rtl/seqCtrl.sv
module seqCtrl
  import seqPkg::*;
#(
  parameter int WR_DELAY = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeWrite,
  input  logic       startBtn,
  input  logic       stopBtn,
  input  logic       tempoClk,
  output seqStrobe_t strobes
);
  localparam int DW = $clog2(WR_DELAY + 1);

  logic          startQ, stopQ, tempoQ, modeQ;
  logic          runFlag;
  logic [DW-1:0] delayCnt;
  logic          pendRelease;
  logic          advPend;

  logic startRise, stopRise, pressEdge, releaseEdge;
  logic modeChange, busy, armEdge, writeNow;

  assign startRise   = startBtn & ~startQ;
  assign stopRise    = stopBtn & ~stopQ;
  assign pressEdge   = (startBtn | stopBtn) & ~(startQ | stopQ);
  assign releaseEdge = ~(startBtn | stopBtn) & (startQ | stopQ);
  assign modeChange  = modeWrite ^ modeQ;
  assign busy        = (delayCnt != '0) | advPend;
  assign armEdge     = modeWrite & ~modeChange & ~busy & (pressEdge | releaseEdge);
  assign writeNow    = (delayCnt == DW'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ      <= 1'b0;
      stopQ       <= 1'b0;
      tempoQ      <= 1'b0;
      modeQ       <= 1'b0;
      runFlag     <= 1'b0;
      delayCnt    <= '0;
      pendRelease <= 1'b0;
      advPend     <= 1'b0;
    end else begin
      startQ <= startBtn;
      stopQ  <= stopBtn;
      tempoQ <= tempoClk;
      modeQ  <= modeWrite;
      if (stopRise)       runFlag <= 1'b0;
      else if (startRise) runFlag <= 1'b1;
      if (modeChange) begin
        delayCnt    <= '0;
        pendRelease <= 1'b0;
        advPend     <= 1'b0;
      end else begin
        if (armEdge) begin
          delayCnt    <= DW'(WR_DELAY);
          pendRelease <= releaseEdge;
        end else if (delayCnt != '0) begin
          delayCnt <= delayCnt - DW'(1);
        end
        advPend <= writeNow & pendRelease;
      end
    end
  end

  always_comb begin
    strobes.wrEn    = writeNow;
    strobes.wrBit   = runFlag;
    strobes.stepInc = modeWrite ? advPend : (runFlag & tempoQ & ~tempoClk);
    strobes.stepClr = modeChange | (~modeWrite & ~runFlag);
    strobes.gate    = ~modeWrite & runFlag & tempoQ;
  end

  // R2: stop dominates a simultaneous start
  assert_stop_wins_R2: assert property (@(posedge clk) disable iff (!rstN)
    (startRise && stopRise) |=> !runFlag);
  // R2: a lone start edge sets the flag
  assert_start_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    (startRise && !stopRise) |=> runFlag);
  // R7: the advance never shares a cycle with a write
  assert_write_before_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEn |-> !strobes.stepInc);
  // R6: writes happen only in write mode
  assert_write_mode_only_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEn |-> modeWrite);
endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import seqPkg::*;
#(
  parameter int RHYTHM_BITS = 3,
  parameter int STEP_BITS   = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seqStrobe_t             strobes,
  input  logic [RHYTHM_BITS-1:0] rhythmSel,
  input  logic                   varAuto,
  input  logic                   varSel,
  input  logic [LANE_SEL_W-1:0]  trackSel,
  input  logic                   hatHalf,
  input  logic                   extAccent,
  output logic                   trigAccent,
  output logic                   trigBass,
  output logic                   trigSnare,
  output logic                   trigRim,
  output logic                   trigHat,
  output logic                   accentExt
);
  localparam int CNT_W  = STEP_BITS + 1;
  localparam int ADDR_W = RHYTHM_BITS + 1 + STEP_BITS;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [CNT_W-1:0]      stepCnt;
  logic [LANE_COUNT-1:0] storeMem [DEPTH];
  logic                  varBit;
  logic [ADDR_W-1:0]     curAddr;
  logic [LANE_COUNT-1:0] curWord, newWord, laneOut;

  assign varBit  = varAuto ? stepCnt[STEP_BITS] : varSel;
  assign curAddr = {rhythmSel, varBit, stepCnt[STEP_BITS-1:0]};
  assign curWord = storeMem[curAddr];

  // read-modify-write: only the selected lane takes the new bit
  always_comb begin
    newWord           = curWord;
    newWord[trackSel] = strobes.wrBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) storeMem[i] <= '0;
    end else if (strobes.wrEn) begin
      storeMem[curAddr] <= newWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                stepCnt <= '0;
    else if (strobes.stepClr) stepCnt <= '0;
    else if (strobes.stepInc) stepCnt <= stepCnt + CNT_W'(1);
  end

  for (genvar g = 0; g < LANE_COUNT; g++) begin : gLane
    assign laneOut[g] = curWord[g] & strobes.gate;
  end

  assign accentExt  = laneOut[0];
  assign trigAccent = laneOut[0] & ~extAccent;
  assign trigBass   = laneOut[1];
  assign trigSnare  = laneOut[2];
  assign trigRim    = laneOut[3];
  assign trigHat    = strobes.gate & (~hatHalf | ~stepCnt[0]);

  // R3: a clear strobe leaves the counter at zero
  assert_step_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stepClr |=> (stepCnt == '0));
  // R4: an advance moves exactly one step with wrap
  assert_step_inc_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stepInc && !strobes.stepClr) |=> (stepCnt == $past(stepCnt) + CNT_W'(1)));
  // R6: unselected lanes keep their old bits
  assert_lane_keep_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEn |=> (((storeMem[$past(curAddr)] ^ $past(curWord))
                      & ~(LANE_COUNT'(1) << $past(trackSel))) == '0));
  // R6: selected lane takes the entered value
  assert_lane_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEn |=> (storeMem[$past(curAddr)][$past(trackSel)] == $past(strobes.wrBit)));
  // R8: nothing leaves the block outside the gated phase
  assert_quiet_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.gate |-> (!trigAccent && !trigBass && !trigSnare && !trigRim && !trigHat && !accentExt));
  // R9: external accent mutes the internal one
  assert_accent_mute_R9: assert property (@(posedge clk) disable iff (!rstN)
    extAccent |-> !trigAccent);
endmodule

// File: rtl/drumStepSeq.sv
module drumStepSeq
  import seqPkg::*;
#(
  parameter int RHYTHM_BITS = 3,
  parameter int STEP_BITS   = 4,
  parameter int WR_DELAY    = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   modeWrite,
  input  logic                   startBtn,
  input  logic                   stopBtn,
  input  logic                   tempoClk,
  input  logic [RHYTHM_BITS-1:0] rhythmSel,
  input  logic                   varAuto,
  input  logic                   varSel,
  input  logic [LANE_SEL_W-1:0]  trackSel,
  input  logic                   hatHalf,
  input  logic                   extAccent,
  output logic                   trigAccent,
  output logic                   trigBass,
  output logic                   trigSnare,
  output logic                   trigRim,
  output logic                   trigHat,
  output logic                   accentExt
);
  seqStrobe_t strobes;

  seqCtrl #(.WR_DELAY(WR_DELAY)) i_ctrl (
    .clk(clk), .rstN(rstN), .modeWrite(modeWrite),
    .startBtn(startBtn), .stopBtn(stopBtn), .tempoClk(tempoClk),
    .strobes(strobes)
  );

  seqDatapath #(.RHYTHM_BITS(RHYTHM_BITS), .STEP_BITS(STEP_BITS)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .rhythmSel(rhythmSel), .varAuto(varAuto), .varSel(varSel),
    .trackSel(trackSel), .hatHalf(hatHalf), .extAccent(extAccent),
    .trigAccent(trigAccent), .trigBass(trigBass), .trigSnare(trigSnare),
    .trigRim(trigRim), .trigHat(trigHat), .accentExt(accentExt)
  );
endmodule

// File: tb/test_drumStepSeq.sv
module test_drumStepSeq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeWrite = 1'b0, startBtn = 1'b0, stopBtn = 1'b0, tempoClk = 1'b0;
  logic [2:0] rhythmSel = '0;
  logic varAuto = 1'b0, varSel = 1'b0, hatHalf = 1'b0, extAccent = 1'b0;
  logic [1:0] trackSel = '0;
  logic trigAccent, trigBass, trigSnare, trigRim, trigHat, accentExt;

  always #10 clk = ~clk;

  drumStepSeq i_drumStepSeq (
    .clk(clk), .rstN(rstN), .modeWrite(modeWrite), .startBtn(startBtn),
    .stopBtn(stopBtn), .tempoClk(tempoClk), .rhythmSel(rhythmSel),
    .varAuto(varAuto), .varSel(varSel), .trackSel(trackSel),
    .hatHalf(hatHalf), .extAccent(extAccent), .trigAccent(trigAccent),
    .trigBass(trigBass), .trigSnare(trigSnare), .trigRim(trigRim),
    .trigHat(trigHat), .accentExt(accentExt)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [3:0] refMem [256];
  logic [4:0] refStep;

  // play table: [12:10] rhythm [9] varAuto [8] varSel [7] hatHalf [6] extAccent [5:0] steps
  localparam int PLAY_N = 5;
  localparam logic [12:0] playTab [PLAY_N] = '{
    {3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 6'd16},
    {3'd2, 1'b0, 1'b0, 1'b1, 1'b1, 6'd18},
    {3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 6'd16},
    {3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 6'd34},
    {3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd4}
  };

  function automatic logic [7:0] refAddr(logic [4:0] s);
    return {rhythmSel, (varAuto ? s[4] : varSel), s[3:0]};
  endfunction

  // {hat, rim, snare, bass, accent, accentExt}
  function automatic logic [5:0] expectAt(logic [4:0] s);
    logic [3:0] w;
    w = refMem[refAddr(s)];
    return {(!hatHalf || !s[0]), w[3], w[2], w[1], w[0] & !extAccent, w[0]};
  endfunction

  function automatic logic [5:0] outNow();
    return {trigHat, trigRim, trigSnare, trigBass, trigAccent, accentExt};
  endfunction

  task automatic check(logic [5:0] exp, string tag);
    checks++;
    if (outNow() !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b (step %0d)", tag, outNow(), exp, refStep);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // one tempo period; checks the high and the low phase
  task automatic tempoPulse(logic [5:0] expHigh, string tag);
    tempoClk = 1'b1;
    @(negedge clk);
    check(expHigh, tag);
    tempoClk = 1'b0;
    @(negedge clk);
    check(6'b0, {tag, " R8 low phase"});
  endtask

  task automatic tapButton(bit isStart);
    if (isStart) startBtn = 1'b1; else stopBtn = 1'b1;
    waitCyc(2);
    startBtn = 1'b0; stopBtn = 1'b0;
    waitCyc(2);
  endtask

  task automatic enterWrite();
    modeWrite = 1'b0; waitCyc(2);
    modeWrite = 1'b1; waitCyc(2);
    refStep = '0;               // R12 mode change clears the step
  endtask

  task automatic writeKey(bit isStart);
    if (isStart) startBtn = 1'b1; else stopBtn = 1'b1;
    waitCyc(8);
    startBtn = 1'b0; stopBtn = 1'b0;
    waitCyc(8);
    refMem[refAddr(refStep)][trackSel] = isStart;
    refStep++;
  endtask

  task automatic enterPlayRunning();
    modeWrite = 1'b0; waitCyc(2);
    tapButton(1'b0);
    tapButton(1'b1);
    refStep = '0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 256; i++) refMem[i] = '0;
    refStep = '0;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    check(6'b0, "R8 reset state");

    // R11 cleared storage: only the hat sounds
    enterPlayRunning();
    tempoPulse(6'b100000, "R11 cleared storage");

    // write programs (R6 R7 R12)
    rhythmSel = 3'd2; varAuto = 1'b0; varSel = 1'b0;
    for (int lane = 0; lane < 4; lane++) begin
      trackSel = 2'(lane);
      enterWrite();
      for (int s = 0; s < 16; s++) writeKey(((s + lane) % 3) == 0);
    end
    varSel = 1'b1; trackSel = 2'd1;
    enterWrite();
    for (int s = 0; s < 16; s++) writeKey(s[0]);
    rhythmSel = 3'd5; varAuto = 1'b1; varSel = 1'b0; trackSel = 2'd2;
    enterWrite();
    for (int s = 0; s < 20; s++) writeKey((s % 4 == 1) || (s >= 16));

    // table-driven playback
    for (int e = 0; e < PLAY_N; e++) begin
      rhythmSel = playTab[e][12:10];
      varAuto   = playTab[e][9];
      varSel    = playTab[e][8];
      hatHalf   = playTab[e][7];
      extAccent = playTab[e][6];
      enterPlayRunning();
      for (int k = 0; k < int'(playTab[e][5:0]); k++) begin
        tempoPulse(expectAt(refStep), "R1 R4 R5 R6 R7 R8 R9 R10 playback");
        refStep++;
      end
    end

    // R3 stopped: no triggers, counter held
    rhythmSel = 3'd2; varAuto = 1'b0; varSel = 1'b0; hatHalf = 1'b0; extAccent = 1'b0;
    modeWrite = 1'b0; waitCyc(2);
    tapButton(1'b0);
    for (int k = 0; k < 3; k++) tempoPulse(6'b0, "R3 stopped quiet");
    tapButton(1'b1);
    refStep = '0;
    tempoPulse(expectAt(5'd0), "R3 restart at step 0");

    // R2 simultaneous start and stop: stop wins
    refStep = 5'd1;
    tempoPulse(expectAt(5'd1), "R2 running before clash");
    startBtn = 1'b1; stopBtn = 1'b1;
    waitCyc(2);
    startBtn = 1'b0; stopBtn = 1'b0;
    waitCyc(2);
    tempoPulse(6'b0, "R2 stop wins clash");
    tapButton(1'b1);
    refStep = '0;
    tempoPulse(expectAt(5'd0), "R2 resume from step 0");

    // R12 mode change mid-run clears counter
    tempoPulse(expectAt(5'd1), "R12 step 1 before mode change");
    modeWrite = 1'b1; waitCyc(2);
    modeWrite = 1'b0; waitCyc(2);
    tempoPulse(expectAt(5'd0), "R12 counter cleared by mode change");

    finishRun();
  end
endmodule